// File: doc/BRIEF.md
# Assignment and Method Emission Unit

This unit sits behind the arithmetic stage of a small command-processing engine. For each value-producing instruction it receives the computed result, a 3-bit assignment mode and a destination register index. From these it decides four things: what to write back to the register file, whether to reload its method address and stride, whether to take a parameter word from an input FIFO, and whether to emit a (method address, data) pair downstream.

Emitted pairs leave on a valid/ready interface. The unit keeps the instruction until the receiver accepts the pair. After each accepted emission the 12-bit method address advances by the 6-bit stride, wrapping modulo 4096. When a parameter is needed and the FIFO is empty, the unit waits without side effects.

A guard counts emissions aimed at one designated method address within a run. It raises a sticky error once that count goes past a limit. A run-start pulse clears the count, the error, the address and the stride.

Top module: `asg_emit_unit`

## Requirements
- R1: After reset, in_ready is 1 and out_valid, wr_en, prm_pop and call_err are 0. The method address and stride are both 0, so a mode-4 send right after reset emits at address 0.
- R2: Mode 1 writes the result to the destination register (wr_idx = in_dst). It pops no parameter and emits nothing.
- R3: Modes 0 and 5 pop one parameter and write it to the destination register. In mode 0 the result has no effect on any output.
- R4: Modes 2, 5, 6 and 7 load the method address from result bits 11:0 and the stride from result bits 17:12. Mode 2 writes the result and does not send.
- R5: Each send carries the current method address on out_addr. Once the send is accepted, the address advances by the stride modulo 4096. Mode 4 writes the result and sends the result.
- R6: Mode 6 writes the result, loads the address and sends one popped parameter at the new address. Mode 7 writes the result, loads the address and sends result bits 17:12, zero-extended, at the new address.
- R7: Mode 3 pops one parameter and writes it to the destination. It sends the result at the current address.
- R8: If the mode needs a parameter and prm_empty is 1, there is no pop, no write and no send. The instruction completes on the clock edge after prm_empty falls.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_addr and out_data hold steady and in_ready stays 0.
- R10: Sends to method address 0x585 are counted. call_err rises together with out_valid of the send that makes the count exceed CALL_LIMIT (default 500) and then stays high. A run_start pulse clears the count, call_err, the address and the stride.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | One-cycle pulse marking the start of a run |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can take an instruction |
| in_mode | input | 3 | Assignment mode |
| in_dst | input | IDX_W | Destination register index |
| in_result | input | DATA_W | Computed result |
| prm_empty | input | 1 | Parameter FIFO empty |
| prm_data | input | DATA_W | Head word of the parameter FIFO |
| prm_pop | output | 1 | Consume the head parameter word |
| wr_en | output | 1 | Register write strobe (one cycle) |
| wr_idx | output | IDX_W | Register write index |
| wr_data | output | DATA_W | Register write data |
| out_valid | output | 1 | Method pair available |
| out_ready | input | 1 | Receiver accepts the pair |
| out_addr | output | ADDR_W | Method address |
| out_data | output | DATA_W | Method data |
| call_err | output | 1 | Sticky limit error for the designated method address |

## Verification
An instruction presented on one cycle is captured at the next edge. Its register write and its send, if any, become visible after the following edge, which is two edges after the stimulus, and the error flag is due at the same point. The address advance becomes visible only in the next send, one edge after acceptance. The bench drives every input at the falling edge and samples every output exactly two falling edges after an instruction is driven. It then lets the acceptance edge pass before driving the next instruction. In the stall and back-pressure cases it counts falling edges from the release of the FIFO or the receiver, and it expects the result one edge later.

// File: rtl/asg_pkg.sv
package asg_pkg;

  typedef enum logic [1:0] {
    SRC_RESULT = 2'd0,
    SRC_PARAM  = 2'd1,
    SRC_HIGH   = 2'd2
  } send_src_e;

  typedef struct packed {
    logic      wr_param;
    logic      set_addr;
    logic      send;
    send_src_e src;
  } mode_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_SEND = 2'd2
  } state_e;

  function automatic mode_ctl_t decode_mode(input logic [2:0] m);
    mode_ctl_t c;
    c = '{wr_param: 1'b0, set_addr: 1'b0, send: 1'b0, src: SRC_RESULT};
    case (m)
      3'd0: c.wr_param = 1'b1;
      3'd1: ;
      3'd2: c.set_addr = 1'b1;
      3'd3: begin c.wr_param = 1'b1; c.send = 1'b1; end
      3'd4: c.send = 1'b1;
      3'd5: begin c.wr_param = 1'b1; c.set_addr = 1'b1; end
      3'd6: begin c.set_addr = 1'b1; c.send = 1'b1; c.src = SRC_PARAM; end
      default: begin c.set_addr = 1'b1; c.send = 1'b1; c.src = SRC_HIGH; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/asg_mode_decode.sv
module asg_mode_decode
  import asg_pkg::*;
(
  input  logic [2:0] mode,
  output mode_ctl_t  ctl,
  output logic       need_param
);
  always_comb begin
    ctl        = decode_mode(mode);
    need_param = ctl.wr_param | (ctl.send & (ctl.src == SRC_PARAM));
  end
endmodule

// File: rtl/asg_addr_track.sv
module asg_addr_track #(
  parameter int ADDR_W   = 12,
  parameter int STRIDE_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                set_en,
  input  logic [ADDR_W-1:0]   set_addr,
  input  logic [STRIDE_W-1:0] set_stride,
  input  logic                adv_en,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [STRIDE_W-1:0] stride_q
);
  localparam int PAD_W = ADDR_W - STRIDE_W;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      addr_q   <= '0;
      stride_q <= '0;
    end else if (set_en) begin
      addr_q   <= set_addr;
      stride_q <= set_stride;
    end else if (adv_en) begin
      addr_q   <= addr_q + {{PAD_W{1'b0}}, stride_q};
    end
  end
endmodule

// File: rtl/asg_call_limiter.sv
module asg_call_limiter #(
  parameter int              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] HOT_ADDR = 12'h585,
  parameter int              CALL_LIMIT = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              hit_en,
  input  logic [ADDR_W-1:0] hit_addr,
  output logic              err_q
);
  localparam int CNT_W = $clog2(CALL_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CALL_LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit = hit_en && (hit_addr == HOT_ADDR);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (hit) begin
      if (cnt_q == CNT_MAX) err_q <= 1'b1;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/asg_emit_unit.sv
module asg_emit_unit
  import asg_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              IDX_W      = 3,
  parameter int              ADDR_W     = 12,
  parameter int              STRIDE_W   = 6,
  parameter logic [ADDR_W-1:0] HOT_ADDR = 12'h585,
  parameter int              CALL_LIMIT = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_mode,
  input  logic [IDX_W-1:0]  in_dst,
  input  logic [DATA_W-1:0] in_result,
  input  logic              prm_empty,
  input  logic [DATA_W-1:0] prm_data,
  output logic              prm_pop,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              call_err
);
  localparam int HIGH_PAD = DATA_W - STRIDE_W;

  state_e              state_q;
  logic [2:0]          mode_q;
  logic [IDX_W-1:0]    dst_q;
  logic [DATA_W-1:0]   res_q;

  mode_ctl_t           ctl;
  logic                need_param;
  logic                exec_go;
  logic                accept;
  logic [ADDR_W-1:0]   new_addr;
  logic [STRIDE_W-1:0] new_stride;
  logic [ADDR_W-1:0]   cur_addr;
  logic [STRIDE_W-1:0] cur_stride;
  logic [ADDR_W-1:0]   send_addr;
  logic [DATA_W-1:0]   send_data;

  asg_mode_decode u_dec (
    .mode       (mode_q),
    .ctl        (ctl),
    .need_param (need_param)
  );

  assign in_ready   = (state_q == ST_IDLE);
  assign exec_go    = (state_q == ST_EXEC) && !(need_param && prm_empty);
  assign prm_pop    = exec_go && need_param;
  assign accept     = (state_q == ST_SEND) && out_ready;
  assign new_addr   = res_q[ADDR_W-1:0];
  assign new_stride = res_q[ADDR_W +: STRIDE_W];
  assign send_addr  = ctl.set_addr ? new_addr : cur_addr;

  always_comb begin
    case (ctl.src)
      SRC_PARAM: send_data = prm_data;
      SRC_HIGH:  send_data = {{HIGH_PAD{1'b0}}, new_stride};
      default:   send_data = res_q;
    endcase
  end

  asg_addr_track #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .clear      (run_start),
    .set_en     (exec_go && ctl.set_addr),
    .set_addr   (new_addr),
    .set_stride (new_stride),
    .adv_en     (accept),
    .addr_q     (cur_addr),
    .stride_q   (cur_stride)
  );

  asg_call_limiter #(.ADDR_W(ADDR_W), .HOT_ADDR(HOT_ADDR), .CALL_LIMIT(CALL_LIMIT)) u_lim (
    .clk      (clk),
    .rst      (rst),
    .clear    (run_start),
    .hit_en   (exec_go && ctl.send),
    .hit_addr (send_addr),
    .err_q    (call_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      dst_q   <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid) begin
          mode_q  <= in_mode;
          dst_q   <= in_dst;
          res_q   <= in_result;
          state_q <= ST_EXEC;
        end
        ST_EXEC: if (exec_go) state_q <= ctl.send ? ST_SEND : ST_IDLE;
        ST_SEND: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      wr_en <= exec_go;
      if (exec_go) begin
        wr_idx  <= dst_q;
        wr_data <= ctl.wr_param ? prm_data : res_q;
      end
      if (exec_go && ctl.send) begin
        out_valid <= 1'b1;
        out_addr  <= send_addr;
        out_data  <= send_data;
      end else if (accept) begin
        out_valid <= 1'b0;
      end
    end
  end

  logic unused_ok;
  assign unused_ok = ^cur_stride;
endmodule

// File: rtl/asg_emit_unit_chk.sv
module asg_emit_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              run_start,
  input logic              in_ready,
  input logic              prm_empty,
  input logic              prm_pop,
  input logic              wr_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data,
  input logic              call_err
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data)); // R9
  AST_BUSY_WHILE_SEND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R9
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    prm_pop |-> !prm_empty); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    call_err && !run_start |=> call_err); // R10
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    run_start |=> !call_err); // R10
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R2
endmodule

bind asg_emit_unit asg_emit_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run_start (run_start),
  .in_ready  (in_ready),
  .prm_empty (prm_empty),
  .prm_pop   (prm_pop),
  .wr_en     (wr_en),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_data  (out_data),
  .call_err  (call_err)
);

// File: tb/sim_asg_emit_unit.sv
`timescale 1ns/1ps
module sim_asg_emit_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = '0;
  logic [2:0]  in_dst = '0;
  logic [31:0] in_result = '0;
  logic        prm_empty;
  logic [31:0] prm_data;
  logic        prm_pop;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [31:0] wr_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_addr;
  logic [31:0] out_data;
  logic        call_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  logic [31:0] pq [0:15];
  int wp = 0;
  int rp = 0;
  assign prm_empty = (wp == rp);
  assign prm_data  = pq[rp[3:0]];
  always @(posedge clk) if (prm_pop) rp <= rp + 1;

  asg_emit_unit u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] v);
    pq[wp[3:0]] = v;
    wp = wp + 1;
  endtask

  // drive at a falling edge, sample two falling edges later
  task automatic issue(input logic [2:0] m, input logic [2:0] d, input logic [31:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_dst = d; in_result = r;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [2:0]  m;
    logic [2:0]  d;
    logic [31:0] r;
    logic        use_p;
    logic [31:0] p;
    logic [31:0] ew;
    logic        es;
    logic [11:0] ea;
    logic [31:0] ed;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{3'd4, 3'd1, 32'h0000_0042, 1'b0, 32'h0,         32'h0000_0042, 1'b1, 12'h000, 32'h0000_0042}, // R1 R5
    '{3'd1, 3'd2, 32'h1234_5678, 1'b0, 32'h0,         32'h1234_5678, 1'b0, 12'h000, 32'h0},         // R2
    '{3'd0, 3'd3, 32'hDEAD_BEEF, 1'b1, 32'h0000_00AA, 32'h0000_00AA, 1'b0, 12'h000, 32'h0},         // R3
    '{3'd2, 3'd1, 32'h0000_3100, 1'b0, 32'h0,         32'h0000_3100, 1'b0, 12'h000, 32'h0},         // R4
    '{3'd4, 3'd4, 32'h0000_0055, 1'b0, 32'h0,         32'h0000_0055, 1'b1, 12'h100, 32'h0000_0055}, // R5
    '{3'd3, 3'd5, 32'h0000_0066, 1'b1, 32'h0000_0077, 32'h0000_0077, 1'b1, 12'h103, 32'h0000_0066}, // R7
    '{3'd5, 3'd6, 32'h0002_0FFE, 1'b1, 32'h0000_0088, 32'h0000_0088, 1'b0, 12'h000, 32'h0},         // R3 R4
    '{3'd4, 3'd7, 32'h0000_0099, 1'b0, 32'h0,         32'h0000_0099, 1'b1, 12'hFFE, 32'h0000_0099}, // R5
    '{3'd4, 3'd0, 32'h0000_00AB, 1'b0, 32'h0,         32'h0000_00AB, 1'b1, 12'h01E, 32'h0000_00AB}, // R5 wrap
    '{3'd6, 3'd1, 32'h0000_5200, 1'b1, 32'h0000_CAFE, 32'h0000_5200, 1'b1, 12'h200, 32'h0000_CAFE}, // R6
    '{3'd7, 3'd2, 32'h0003_F010, 1'b0, 32'h0,         32'h0003_F010, 1'b1, 12'h010, 32'h0000_003F}, // R6
    '{3'd4, 3'd3, 32'h0000_0001, 1'b0, 32'h0,         32'h0000_0001, 1'b1, 12'h04F, 32'h0000_0001}  // R5
  };

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 wr_en", {31'd0, wr_en}, 32'd0);
    chk("R1 prm_pop", {31'd0, prm_pop}, 32'd0);
    chk("R1 call_err", {31'd0, call_err}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      int rp0;
      if (VT[i].use_p) push(VT[i].p);
      rp0 = rp;
      issue(VT[i].m, VT[i].d, VT[i].r);
      chk($sformatf("R2-R7 vec%0d wr_en", i), {31'd0, wr_en}, 32'd1);
      chk($sformatf("R2-R7 vec%0d wr_idx", i), {29'd0, wr_idx}, {29'd0, VT[i].d});
      chk($sformatf("R2-R7 vec%0d wr_data", i), wr_data, VT[i].ew);
      chk($sformatf("R2-R7 vec%0d out_valid", i), {31'd0, out_valid}, {31'd0, VT[i].es});
      chk($sformatf("R3 R8 vec%0d pops", i), rp - rp0, {31'd0, VT[i].use_p});
      if (VT[i].es) begin
        chk($sformatf("R5 vec%0d out_addr", i), {20'd0, out_addr}, {20'd0, VT[i].ea});
        chk($sformatf("R5 R6 vec%0d out_data", i), out_data, VT[i].ed);
      end
    end

    // R8: parameter stall
    @(negedge clk);
    in_valid = 1'b1; in_mode = 3'd0; in_dst = 3'd5; in_result = 32'h1111;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 no write while empty", {31'd0, wr_en}, 32'd0);
      chk("R8 no pop while empty", {31'd0, prm_pop}, 32'd0);
    end
    push(32'h0000_4242);
    @(negedge clk);
    chk("R8 write after data", {31'd0, wr_en}, 32'd1);
    chk("R8 R3 data", wr_data, 32'h0000_4242);
    chk("R8 no send", {31'd0, out_valid}, 32'd0);

    // R9: back-pressure
    out_ready = 1'b0;
    issue(3'd4, 3'd1, 32'h0000_0077);
    chk("R9 valid", {31'd0, out_valid}, 32'd1);
    chk("R9 addr", {20'd0, out_addr}, 32'h08E);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 held valid", {31'd0, out_valid}, 32'd1);
      chk("R9 held addr", {20'd0, out_addr}, 32'h08E);
      chk("R9 held data", out_data, 32'h0000_0077);
      chk("R9 in_ready low", {31'd0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 released", {31'd0, out_valid}, 32'd0);
    chk("R9 in_ready back", {31'd0, in_ready}, 32'd1);
    issue(3'd4, 3'd2, 32'h0000_0078);
    chk("R5 advance after hold", {20'd0, out_addr}, 32'h0CD);

    // R10: call limit
    issue(3'd2, 3'd1, 32'h0000_0585);
    for (int k = 0; k < 500; k++) issue(3'd4, 3'd3, k);
    chk("R10 no error at limit", {31'd0, call_err}, 32'd0);
    issue(3'd4, 3'd3, 32'h0000_1F5);
    chk("R10 hot address", {20'd0, out_addr}, 32'h585);
    chk("R10 error past limit", {31'd0, call_err}, 32'd1);
    @(negedge clk);
    chk("R10 error sticky", {31'd0, call_err}, 32'd1);
    run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
    chk("R10 cleared by run_start", {31'd0, call_err}, 32'd0);
    issue(3'd4, 3'd3, 32'h0000_0005);
    chk("R10 address cleared", {20'd0, out_addr}, 32'h000);
    chk("R10 no error new run", {31'd0, call_err}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule